// File: doc/BRIEF.md
# Endian-Aware Byte Lane Aligner

This block sits between a load/store unit and an eight-byte-wide memory path. For every request it takes the low three bits of the physical address, an access size written as the byte count minus one, an endianness flag, a direction and a data word. It then moves the data to the byte lanes it belongs in. A load takes a right-aligned fetched value and shifts it up into its lane. A store takes lane-positioned data and shifts it down to the low end. For stores it also produces a byte-enable mask that names the lanes being written.

Requests whose offset plus encoded size runs past the last byte of the element are reported as boundary-crossing errors. Such a request produces zero data and an empty mask. Results leave through one register stage, with a valid strobe one cycle after the request. Between requests the outputs hold their last values.

Top module: `lane_aligner`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid`, `data_out`, `byte_en` and `cross_err` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. A cycle with `req_valid` low leaves `data_out`, `byte_en` and `cross_err` at their previous values.
- R3: A request with `addr_off + len_code > 7` (both unsigned, `len_code` = byte count − 1) sets `cross_err` and returns `data_out` = 0 and `byte_en` = 0. Any other request clears `cross_err`.
- R4: A little-endian load (`big_endian`=0, `req_store`=0) returns `data_in` shifted left by 8·`addr_off` bits.
- R5: A big-endian load (`big_endian`=1) returns `data_in` shifted left by 8·(7 − `addr_off` − `len_code`) bits.
- R6: A store (`req_store`=1) returns `data_in` shifted right by the same byte count that R4 or R5 gives for its endianness.
- R7: A full-element access (`len_code`=7, `addr_off`=0) returns `data_in` unchanged, for both directions and both endiannesses.
- R8: For a store that does not cross, `byte_en` bit i (data bits 8i+7..8i) is set exactly for lanes i from s to s+`len_code`, where s is the R4/R5 shift in bytes. A load always returns `byte_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| big_endian | input | 1 | 1 = big-endian lane order |
| addr_off | input | 3 | Physical address bits 2:0 |
| len_code | input | 3 | Byte count minus one |
| data_in | input | 64 | Fetched value (load) or lane data (store) |
| out_valid | output | 1 | Result valid |
| data_out | output | 64 | Aligned data |
| byte_en | output | 8 | Store lane enables |
| cross_err | output | 1 | Access crossed the element boundary |

## Verification
The assertions assume that the request fields are stable and known in every cycle where `req_valid` is high. They also assume that a crossing request is rejected without any shift, so no check relies on the wrapped shift value such a request would produce. The stimulus drives every field at the falling edge. It covers every offset and size pair of both endiannesses in both directions, on purpose, so crossing cases occur often and on purpose. Random fields from a fixed seed fill in the rest, with idle cycles mixed in.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int LANE_BITS = 8;

  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } dir_e;
endpackage

// File: rtl/lane_shift_calc.sv
module lane_shift_calc #(
  parameter int BYTES = 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic             big_endian,
  input  logic [OFF_W-1:0] addr_off,
  input  logic [OFF_W-1:0] len_code,
  output logic [OFF_W-1:0] shift_bytes,
  output logic             crosses
);
  logic [OFF_W:0] span_end;
  logic [OFF_W:0] be_shift;

  always_comb begin
    span_end = {1'b0, addr_off} + {1'b0, len_code};
    crosses  = span_end > (OFF_W+1)'(BYTES - 1);
    be_shift = (OFF_W+1)'(BYTES - 1) - span_end;
    if (crosses)
      shift_bytes = '0;
    else if (big_endian)
      shift_bytes = be_shift[OFF_W-1:0];
    else
      shift_bytes = addr_off;
  end

  // R8
  always_comb begin
    if (!crosses)
      lane_fits_chk: assert ({1'b0, shift_bytes} + {1'b0, len_code} <= (OFF_W+1)'(BYTES - 1));
  end
endmodule

// File: rtl/lane_barrel.sv
module lane_barrel #(
  parameter int BYTES = 8,
  localparam int W     = BYTES * lane_pkg::LANE_BITS,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [W-1:0]     din,
  input  logic [OFF_W-1:0] amt,
  input  logic             shift_left,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stage [0:OFF_W];

  assign stage[0] = din;

  for (genvar s = 0; s < OFF_W; s++) begin : g_stage
    localparam int STEP = lane_pkg::LANE_BITS << s;
    always_comb begin
      if (!amt[s])
        stage[s+1] = stage[s];
      else if (shift_left)
        stage[s+1] = stage[s] << STEP;
      else
        stage[s+1] = stage[s] >> STEP;
    end
  end

  assign dout = stage[OFF_W];
endmodule

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
  parameter int BYTES = 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0] start,
  input  logic [OFF_W-1:0] len_code,
  output logic [BYTES-1:0] mask
);
  logic [OFF_W:0] last;
  assign last = {1'b0, start} + {1'b0, len_code};

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    localparam logic [OFF_W:0] IDX = (OFF_W+1)'(i);
    assign mask[i] = (IDX >= {1'b0, start}) && (IDX <= last);
  end
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner #(
  parameter int BYTES = 8,
  localparam int W     = BYTES * lane_pkg::LANE_BITS,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             big_endian,
  input  logic [OFF_W-1:0] addr_off,
  input  logic [OFF_W-1:0] len_code,
  input  logic [W-1:0]     data_in,
  output logic             out_valid,
  output logic [W-1:0]     data_out,
  output logic [BYTES-1:0] byte_en,
  output logic             cross_err
);
  import lane_pkg::*;

  logic [OFF_W-1:0] shift_bytes;
  logic             crosses;
  logic [W-1:0]     shifted;
  logic [BYTES-1:0] lane_mask;
  dir_e             dir;

  assign dir = dir_e'(req_store);

  lane_shift_calc #(.BYTES(BYTES)) u_calc (
    .big_endian (big_endian),
    .addr_off   (addr_off),
    .len_code   (len_code),
    .shift_bytes(shift_bytes),
    .crosses    (crosses)
  );

  lane_barrel #(.BYTES(BYTES)) u_barrel (
    .din       (data_in),
    .amt       (shift_bytes),
    .shift_left(dir == DIR_LOAD),
    .dout      (shifted)
  );

  lane_mask_gen #(.BYTES(BYTES)) u_mask (
    .start   (shift_bytes),
    .len_code(len_code),
    .mask    (lane_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      data_out  <= '0;
      byte_en   <= '0;
      cross_err <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        cross_err <= crosses;
        data_out  <= crosses ? '0 : shifted;
        byte_en   <= (crosses || dir == DIR_LOAD) ? '0 : lane_mask;
      end
    end
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && $stable(data_out) && $stable(byte_en) && $stable(cross_err)));

  // R3
  cross_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ({1'b0, addr_off} + {1'b0, len_code} > (OFF_W+1)'(BYTES - 1)))
    |=> (cross_err && data_out == '0 && byte_en == '0));

  // R8
  store_count_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && ({1'b0, addr_off} + {1'b0, len_code} <= (OFF_W+1)'(BYTES - 1)))
    |=> ($countones(byte_en) == int'($past(len_code)) + 1));

  // R8
  load_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_store) |=> (byte_en == '0));

  // R7
  full_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && addr_off == '0 && len_code == OFF_W'(BYTES - 1)) |=> (data_out == $past(data_in)));
endmodule

// File: tb/tb_lane_aligner.sv
module tb_lane_aligner;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_store, big_endian;
  logic [2:0]  addr_off, len_code;
  logic [63:0] data_in;
  logic        out_valid;
  logic [63:0] data_out;
  logic [7:0]  byte_en;
  logic        cross_err;

  int vectors = 0;
  int fails   = 0;
  int seed_dummy;

  always #10 clk = ~clk;

  lane_aligner dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .big_endian(big_endian), .addr_off(addr_off), .len_code(len_code),
    .data_in(data_in), .out_valid(out_valid), .data_out(data_out),
    .byte_en(byte_en), .cross_err(cross_err)
  );

  function automatic bit exp_cross(input int off, input int len);
    return (off + len) > 7;
  endfunction

  function automatic int exp_shift(input bit be, input int off, input int len);
    return be ? (7 - off - len) : off;
  endfunction

  function automatic logic [63:0] exp_data(input bit st, input bit be, input int off,
                                           input int len, input logic [63:0] d);
    if (exp_cross(off, len)) return 64'h0;
    if (st) return d >> (8 * exp_shift(be, off, len));
    return d << (8 * exp_shift(be, off, len));
  endfunction

  function automatic logic [7:0] exp_en(input bit st, input bit be, input int off, input int len);
    logic [8:0] ones;
    if (!st || exp_cross(off, len)) return 8'h0;
    ones = (9'd1 << (len + 1)) - 9'd1;
    return 8'(ones << exp_shift(be, off, len));
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  logic [63:0] last_data;
  logic [7:0]  last_en;
  logic        last_cross;

  task automatic apply(input bit st, input bit be, input int off, input int len,
                       input logic [63:0] d);
    string tag;
    logic [63:0] ed;
    logic [7:0]  ee;
    req_valid  = 1'b1;
    req_store  = st;
    big_endian = be;
    addr_off   = 3'(off);
    len_code   = 3'(len);
    data_in    = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ed = exp_data(st, be, off, len, d);
    ee = exp_en(st, be, off, len);
    if (exp_cross(off, len)) tag = "R3";
    else if (off == 0 && len == 7) tag = "R7";
    else if (st) tag = "R6";
    else if (be) tag = "R5";
    else tag = "R4";
    check("R2", "out_valid", 64'(out_valid), 64'h1);
    check(tag, "data_out", data_out, ed);
    check("R3", "cross_err", 64'(cross_err), 64'(exp_cross(off, len)));
    check("R8", "byte_en", 64'(byte_en), 64'(ee));
    last_data  = ed;
    last_en    = ee;
    last_cross = exp_cross(off, len);
  endtask

  task automatic idle(input logic [63:0] d);
    req_valid = 1'b0;
    req_store = d[0];
    big_endian = d[1];
    addr_off  = d[4:2];
    len_code  = d[7:5];
    data_in   = d;
    @(posedge clk);
    @(negedge clk);
    check("R2", "idle out_valid", 64'(out_valid), 64'h0);
    check("R2", "idle data_out", data_out, last_data);
    check("R2", "idle byte_en", 64'(byte_en), 64'(last_en));
    check("R2", "idle cross_err", 64'(cross_err), 64'(last_cross));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; big_endian = 1'b0;
    addr_off = '0; len_code = '0; data_in = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    check("R1", "out_valid", 64'(out_valid), 64'h0);
    check("R1", "data_out", data_out, 64'h0);
    check("R1", "byte_en", 64'(byte_en), 64'h0);
    check("R1", "cross_err", 64'(cross_err), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "out_valid after release", 64'(out_valid), 64'h0);
    last_data = '0; last_en = '0; last_cross = 1'b0;

    // R7 full element, all four modes
    apply(0, 0, 0, 7, 64'h0123_4567_89AB_CDEF);
    apply(0, 1, 0, 7, 64'h0123_4567_89AB_CDEF);
    apply(1, 0, 0, 7, 64'hFEDC_BA98_7654_3210);
    apply(1, 1, 0, 7, 64'hFEDC_BA98_7654_3210);
    // R4, R5 single bytes at the ends
    apply(0, 0, 7, 0, 64'h0000_0000_0000_00A5);
    apply(0, 1, 7, 0, 64'h0000_0000_0000_00A5);
    apply(0, 1, 0, 0, 64'h0000_0000_0000_005A);
    // R6 halfword store, big-endian
    apply(1, 1, 2, 1, 64'h0000_BEEF_0000_0000);
    // R3 crossings
    apply(0, 0, 1, 7, 64'hDEAD_BEEF_DEAD_BEEF);
    apply(1, 1, 7, 1, 64'hDEAD_BEEF_DEAD_BEEF);
    idle(64'h1234_5678_9ABC_DEF0);
    apply(1, 0, 4, 3, 64'hCAFE_F00D_0000_0000);
    idle(64'h0F0F_0F0F_0F0F_0F0F);

    // exhaustive offset / size sweep
    for (int st = 0; st < 2; st++)
      for (int be = 0; be < 2; be++)
        for (int off = 0; off < 8; off++)
          for (int len = 0; len < 8; len++)
            apply(st[0], be[0], off, len, {$urandom, $urandom});

    // random mix with idle cycles
    for (int n = 0; n < 2000; n++) begin
      automatic logic [31:0] r = $urandom;
      if (r[31:29] == 3'b000) idle({$urandom, $urandom});
      else apply(r[0], r[1], int'(r[4:2]), int'(r[7:5]), {$urandom, $urandom});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule